// File: doc/BRIEF.md
# UDP Transmit Checksum-Insertion Buffer

This block turns a stream of user payload beats into a complete UDP datagram for the IP layer. At the start of each frame it builds an 8-byte UDP header from the current source and destination port settings and the payload byte length. The header goes into an internal frame RAM with its checksum field set to zero, and the payload beats follow it. While the frame is being written, a ones-complement accumulator sums the IPv4 pseudo-header (both IP addresses, the protocol number and the UDP length), the header and the payload.

Once the last payload beat has been taken, the block spends one cycle rewriting RAM word 0 so that it holds the final checksum. It then plays the finished datagram out on a 64-bit output stream. Alongside the stream it presents the total UDP byte length and the protocol number 17.

Both stream interfaces use valid/ready handshakes. A beat moves only in a cycle where valid and ready are both high. On the input side, `in_ready` is high only while payload is being collected. It stays low from the cycle after a frame's last beat is accepted until the drain of that frame has finished. On the output side, the producer must hold data, keep and last unchanged while `out_valid` is high and `out_ready` is low. Port settings and IP addresses are plain control inputs.

Top module: `udp_csum_txbuf`

## Requirements
- R1: After reset, `in_ready` and `out_valid` are low, and both port settings hold 8080 (0x1F90) until a strobe changes them.
- R2: The first output beat of every frame is the header `{src_port[63:48], dst_port[47:32], udp_len[31:16], checksum[15:0]}`, where udp_len = `in_len` + 8.
- R3: Payload beats are output after the header, in input order and with unchanged data. Byte 0 of each beat is `data[63:56]`.
- R4: `keep[k]` qualifies byte `data[8k+7:8k]`. The final output beat carries the keep that came with the input last beat, and every other output beat has keep 0xFF.
- R5: A frame of N payload beats produces exactly N+1 output beats with no gaps. `out_last` is high only on the final beat.
- R6: The checksum is the inverted ones-complement sum, with end-around carry, of 16-bit words drawn from: source IP, destination IP, 17, UDP length, the header with a zero checksum field, and the payload. Payload bytes whose keep bit is clear count as zero.
- R7: When the computed checksum is 0x0000, 0xFFFF is sent in its place.
- R8: `src_port_we` loads `src_port_in` and `dst_port_we` loads `dst_port_in`, each independently of the other. Ports are sampled when a frame starts, so a strobe during a frame affects only later frames.
- R9: `in_ready` is never high in the same cycle as `out_valid`, and it drops in the cycle after the input last beat is accepted.
- R10: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with data, keep and last unchanged.
- R11: During output, `out_len` equals the UDP length and stays stable, and `out_proto` equals 17.
- R12: `out_valid` stays low in the first cycle after the input last beat is accepted (the checksum patch cycle) and rises in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ip | input | 32 | Source IPv4 address for the pseudo-header |
| dst_ip | input | 32 | Destination IPv4 address for the pseudo-header |
| src_port_we | input | 1 | Load strobe for the source port |
| src_port_in | input | 16 | New source port value |
| dst_port_we | input | 1 | Load strobe for the destination port |
| dst_port_in | input | 16 | New destination port value |
| in_data | input | 64 | Payload beat data |
| in_keep | input | 8 | Payload byte qualifiers |
| in_last | input | 1 | Final payload beat of the frame |
| in_valid | input | 1 | Payload beat valid |
| in_ready | output | 1 | Payload beat accepted |
| in_len | input | 16 | Payload byte length, held for the whole frame |
| out_data | output | 64 | Datagram beat data |
| out_keep | output | 8 | Datagram byte qualifiers |
| out_last | output | 1 | Final datagram beat |
| out_valid | output | 1 | Datagram beat valid |
| out_ready | input | 1 | Downstream ready |
| out_len | output | 16 | UDP total byte length |
| out_proto | output | 8 | IP protocol number (17) |

## Verification
The bench builds the block with DEPTH = 8, so a frame can hold at most seven payload beats. This small size lets the bench sweep every payload length from 1 to 56 bytes. That sweep covers every keep pattern of the last beat, with junk placed in the unqualified byte lanes, and every beat count, each under one of four output back-pressure patterns. Port strobes are exercised both between frames and during a frame. A frame whose payload is computed arithmetically to force a zero checksum reaches the 0xFFFF substitution.

// File: rtl/udp_txbuf_pkg.sv
package udp_txbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAY,
    ST_PATCH,
    ST_DRAIN
  } txb_state_e;

  localparam logic [7:0]  PROTO_UDP     = 8'd17;
  localparam logic [15:0] UDP_HDR_BYTES = 16'd8;
  localparam int          CSUM_ACC_W    = 32;

  // Fold a 32-bit running sum into 16 bits with end-around carry.
  function automatic logic [15:0] fold_sum(input logic [CSUM_ACC_W-1:0] a);
    logic [16:0] s1;
    logic [16:0] s2;
    s1 = {1'b0, a[15:0]} + {1'b0, a[31:16]};
    s2 = {1'b0, s1[15:0]} + {16'h0, s1[16]};
    return s2[15:0];
  endfunction

  // Final UDP checksum: inverted fold, zero replaced by all-ones.
  function automatic logic [15:0] final_csum(input logic [CSUM_ACC_W-1:0] a);
    logic [15:0] c;
    c = ~fold_sum(a);
    return (c == 16'h0000) ? 16'hFFFF : c;
  endfunction

endpackage

// File: rtl/udp_frame_ram.sv
module udp_frame_ram #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/udp_csum_acc.sv
module udp_csum_acc
  import udp_txbuf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init,
  input  logic [CSUM_ACC_W-1:0] init_val,
  input  logic                  add_en,
  input  logic [DW-1:0]         add_data,
  input  logic [DW/8-1:0]       add_keep,
  output logic [15:0]           csum
);

  localparam int KW = DW / 8;
  localparam int NW = DW / 16;

  logic [DW-1:0]         masked;
  logic [CSUM_ACC_W-1:0] beat_sum;
  logic [CSUM_ACC_W-1:0] acc;

  // Unqualified bytes contribute zero.
  for (genvar b = 0; b < KW; b++) begin : g_mask
    assign masked[b*8 +: 8] = add_keep[b] ? add_data[b*8 +: 8] : 8'h00;
  end

  always_comb begin
    beat_sum = '0;
    for (int w = 0; w < NW; w++) begin
      beat_sum = beat_sum + {{(CSUM_ACC_W-16){1'b0}}, masked[w*16 +: 16]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (init)   acc <= init_val;
    else if (add_en) acc <= acc + beat_sum;
  end

  assign csum = final_csum(acc);

endmodule

// File: rtl/udp_csum_txbuf.sv
module udp_csum_txbuf
  import udp_txbuf_pkg::*;
#(
  parameter int          DEPTH        = 64,
  parameter logic [15:0] DEF_SRC_PORT = 16'd8080,
  parameter logic [15:0] DEF_DST_PORT = 16'd8080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_ip,
  input  logic [31:0] dst_ip,
  input  logic        src_port_we,
  input  logic [15:0] src_port_in,
  input  logic        dst_port_we,
  input  logic [15:0] dst_port_in,
  input  logic [63:0] in_data,
  input  logic [7:0]  in_keep,
  input  logic        in_last,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_len,
  output logic [63:0] out_data,
  output logic [7:0]  out_keep,
  output logic        out_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_len,
  output logic [7:0]  out_proto
);

  localparam int             DW      = 64;
  localparam int             KW      = DW / 8;
  localparam int             AW      = $clog2(DEPTH);
  localparam logic [AW-1:0]  PTR_ONE = AW'(1);
  localparam logic [AW-1:0]  HDR_ADR = '0;

  txb_state_e    st;
  logic [15:0]   src_cfg, dst_cfg;
  logic [47:0]   hdr_hi;
  logic [15:0]   len_q;
  logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [KW-1:0] last_keep;

  logic          start, in_fire, out_fire;
  logic [15:0]   udp_len;
  logic [CSUM_ACC_W-1:0] pseudo_sum;
  logic [15:0]   csum;

  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;

  // Port configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_cfg <= DEF_SRC_PORT;
      dst_cfg <= DEF_DST_PORT;
    end else begin
      if (src_port_we) src_cfg <= src_port_in;
      if (dst_port_we) dst_cfg <= dst_port_in;
    end
  end

  assign in_ready  = (st == ST_PAY);
  assign out_valid = (st == ST_DRAIN);
  assign start     = (st == ST_IDLE) && in_valid;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign udp_len   = in_len + UDP_HDR_BYTES;

  // Pseudo-header plus header words; the checksum field counts as zero.
  assign pseudo_sum = {16'h0, src_ip[31:16]} + {16'h0, src_ip[15:0]}
                    + {16'h0, dst_ip[31:16]} + {16'h0, dst_ip[15:0]}
                    + {24'h0, PROTO_UDP}
                    + {15'h0, udp_len, 1'b0}
                    + {16'h0, src_cfg} + {16'h0, dst_cfg};

  // Frame sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hdr_hi    <= '0;
      len_q     <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      last_ptr  <= '0;
      last_keep <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (in_valid) begin
            hdr_hi <= {src_cfg, dst_cfg, udp_len};
            len_q  <= udp_len;
            wr_ptr <= PTR_ONE;
            st     <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (in_fire) begin
            wr_ptr <= wr_ptr + PTR_ONE;
            if (in_last) begin
              last_keep <= in_keep;
              last_ptr  <= wr_ptr;
              st        <= ST_PATCH;
            end
          end
        end
        ST_PATCH: begin
          rd_ptr <= HDR_ADR;
          st     <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (out_fire) begin
            if (rd_ptr == last_ptr) st <= ST_IDLE;
            else                    rd_ptr <= rd_ptr + PTR_ONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Single RAM write port: header, payload, then the checksum patch.
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = HDR_ADR;
    ram_wdata = '0;
    if (start) begin
      ram_we    = 1'b1;
      ram_wdata = {src_cfg, dst_cfg, udp_len, 16'h0000};
    end else if ((st == ST_PAY) && in_fire) begin
      ram_we    = 1'b1;
      ram_waddr = wr_ptr;
      ram_wdata = in_data;
    end else if (st == ST_PATCH) begin
      ram_we    = 1'b1;
      ram_wdata = {hdr_hi, csum};
    end
  end

  udp_frame_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (rd_ptr),
    .rdata (out_data)
  );

  udp_csum_acc #(.DW(DW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (start),
    .init_val (pseudo_sum),
    .add_en   (in_fire),
    .add_data (in_data),
    .add_keep (in_keep),
    .csum     (csum)
  );

  assign out_last  = out_valid && (rd_ptr == last_ptr);
  assign out_keep  = out_last ? last_keep : {KW{1'b1}};
  assign out_len   = len_q;
  assign out_proto = PROTO_UDP;

endmodule

// File: rtl/udp_csum_txbuf_chk.sv
module udp_csum_txbuf_chk #(
  parameter int DW = 64,
  parameter int KW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_last,
  input logic [DW-1:0] out_data,
  input logic [KW-1:0] out_keep,
  input logic [15:0]   out_len
);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r9_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  a_r12_patch_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !out_valid ##1 out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last)));

  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r4_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_keep == {KW{1'b1}}));

  a_r11_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_len));

endmodule

bind udp_csum_txbuf udp_csum_txbuf_chk #(.DW(64), .KW(8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_data  (out_data),
  .out_keep  (out_keep),
  .out_len   (out_len)
);

// File: tb/udp_csum_txbuf_tb_top.sv
module udp_csum_txbuf_tb_top;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_ip = '0, dst_ip = '0;
  logic        src_port_we = 1'b0, dst_port_we = 1'b0;
  logic [15:0] src_port_in = '0, dst_port_in = '0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_keep = '0;
  logic        in_last = 1'b0, in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_len = '0;
  logic [63:0] out_data;
  logic [7:0]  out_keep;
  logic        out_last, out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_len;
  logic [7:0]  out_proto;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done = 1'b0;

  byte unsigned pay [0:63];
  logic [63:0]  drv [0:7];
  logic [15:0]  cur_sp, cur_dp;

  always #5 clk = ~clk;

  udp_csum_txbuf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_ip(src_ip), .dst_ip(dst_ip),
    .src_port_we(src_port_we), .src_port_in(src_port_in),
    .dst_port_we(dst_port_we), .dst_port_in(dst_port_in),
    .in_data(in_data), .in_keep(in_keep), .in_last(in_last),
    .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
    .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
    .out_proto(out_proto)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fold_ref(input int len, input logic [15:0] sp, input logic [15:0] dp);
    int unsigned s;
    int unsigned ulen;
    ulen = len + 8;
    s = 0;
    s = s + src_ip[31:16] + src_ip[15:0] + dst_ip[31:16] + dst_ip[15:0];
    s = s + 17 + 2 * ulen + sp + dp;
    for (int i = 0; i < len; i += 2) begin
      s = s + (int'(pay[i]) << 8) + ((i + 1 < len) ? int'(pay[i+1]) : 0);
    end
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  function automatic logic [15:0] csum_ref(input int len, input logic [15:0] sp, input logic [15:0] dp);
    logic [15:0] c;
    c = ~fold_ref(len, sp, dp);
    return (c == 16'h0000) ? 16'hFFFF : c;
  endfunction

  function automatic bit rdy_pat(input int mode, input int cyc);
    case (mode)
      0:       return 1'b1;
      1:       return (cyc % 2) == 0;
      2:       return (cyc % 3) != 2;
      default: return (cyc % 4) == 3;
    endcase
  endfunction

  task automatic run_frame(input int len, input int bp, input bit strobe,
                           input logic [15:0] nsp, input logic [15:0] ndp, input bit zero_case);
    int nb, lastn, idx, cyc;
    logic [7:0]  lkeep;
    logic [15:0] csum;
    logic [63:0] exp_d, pd;
    logic [7:0]  exp_k, pk;
    logic        pl, stall, acc, rdy;
    nb    = (len + 7) / 8;
    lastn = len - 8 * (nb - 1);
    lkeep = 8'hFF << (8 - lastn);
    for (int b = 0; b < nb; b++) begin
      for (int j = 0; j < 8; j++) begin
        int k;
        k = b * 8 + j;
        drv[b][63 - 8*j -: 8] = (k < len) ? pay[k] : (8'hA5 ^ k[7:0]);
      end
    end
    csum = csum_ref(len, cur_sp, cur_dp);
    in_len = 16'(len);
    for (int b = 0; b < nb; b++) begin
      in_data  = drv[b];
      in_keep  = (b == nb - 1) ? lkeep : 8'hFF;
      in_last  = (b == nb - 1);
      in_valid = 1'b1;
      if (strobe && b == nb - 1) begin
        src_port_we = 1'b1; src_port_in = nsp;
        dst_port_we = 1'b1; dst_port_in = ndp;
      end
      forever begin
        acc = in_ready;
        @(negedge clk);
        src_port_we = 1'b0;
        dst_port_we = 1'b0;
        if (acc) break;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(out_valid == 1'b0, "R12 patch cycle valid", {63'h0, out_valid}, 64'h0);
    chk(in_ready == 1'b0, "R9 ready after last", {63'h0, in_ready}, 64'h0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R12 drain start", {63'h0, out_valid}, 64'h1);
    idx = 0; cyc = 0; stall = 1'b0; pd = '0; pk = '0; pl = 1'b0;
    while (idx <= nb && cyc < 1000) begin
      rdy = rdy_pat(bp, cyc);
      out_ready = rdy;
      if (stall)
        chk(out_valid && out_data == pd && out_keep == pk && out_last == pl,
            "R10 hold under stall", out_data, pd);
      chk(in_ready == 1'b0, "R9 ready during drain", {63'h0, in_ready}, 64'h0);
      if (!out_valid) begin
        chk(1'b0, "R5 gap in output", 64'h0, 64'h1);
      end else if (rdy) begin
        if (idx == 0) begin
          exp_d = {cur_sp, cur_dp, 16'(len + 8), csum};
          chk(out_data[63:32] == exp_d[63:32], "R1 R8 header ports", {32'h0, out_data[63:32]}, {32'h0, exp_d[63:32]});
          chk(out_data[31:16] == exp_d[31:16], "R2 udp length", {48'h0, out_data[31:16]}, {48'h0, exp_d[31:16]});
          chk(out_data[15:0] == csum, "R6 checksum", {48'h0, out_data[15:0]}, {48'h0, csum});
          if (zero_case)
            chk(out_data[15:0] == 16'hFFFF, "R7 zero substitute", {48'h0, out_data[15:0]}, 64'hFFFF);
        end else begin
          exp_d = drv[idx-1];
          chk(out_data == exp_d, "R3 payload beat", out_data, exp_d);
        end
        exp_k = (idx == nb) ? lkeep : 8'hFF;
        chk(out_keep == exp_k, "R4 keep", {56'h0, out_keep}, {56'h0, exp_k});
        chk(out_last == (idx == nb), "R5 last flag", {63'h0, out_last}, {63'h0, idx == nb});
        chk(out_len == 16'(len + 8) && out_proto == 8'd17, "R11 sideband",
            {40'h0, out_proto, out_len}, {40'h0, 8'd17, 16'(len + 8)});
        idx++;
        stall = 1'b0;
      end else begin
        stall = 1'b1; pd = out_data; pk = out_keep; pl = out_last;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R5 no extra beat", {63'h0, out_valid}, 64'h0);
    if (strobe) begin
      cur_sp = nsp;
      cur_dp = ndp;
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin : main
    cur_sp = 16'd8080;
    cur_dp = 16'd8080;
    src_ip = 32'hC0A8_0001;
    dst_ip = 32'hC0A8_00FE;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R1 reset outputs",
        {62'h0, in_ready, out_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Default ports on the first frame (R1).
    for (int i = 0; i < 64; i++) pay[i] = 8'((i * 29 + 3) & 8'hFF);
    run_frame(13, 0, 1'b0, 16'h0, 16'h0, 1'b0);

    // R8: source strobe alone.
    src_port_we = 1'b1; src_port_in = 16'h1234;
    @(negedge clk);
    src_port_we = 1'b0;
    cur_sp = 16'h1234;
    run_frame(8, 1, 1'b0, 16'h0, 16'h0, 1'b0);

    // R8: destination strobe alone.
    dst_port_we = 1'b1; dst_port_in = 16'hABCD;
    @(negedge clk);
    dst_port_we = 1'b0;
    cur_dp = 16'hABCD;
    run_frame(9, 2, 1'b0, 16'h0, 16'h0, 1'b0);

    // Every payload length that fits, with mid-frame strobes on some.
    for (int len = 1; len <= (DEPTH - 1) * 8; len++) begin
      for (int i = 0; i < 64; i++) pay[i] = 8'((i * 37 + len * 11 + 5) & 8'hFF);
      src_ip = 32'h0A00_0000 + 32'(len * 257);
      dst_ip = 32'hAC10_FF00 ^ 32'(len * 4099);
      run_frame(len, len % 4, (len % 5) == 0,
                16'h4000 + 16'(len), 16'h8000 ^ 16'(len * 3), 1'b0);
    end

    // R7: payload chosen so the checksum computes to zero.
    for (int i = 0; i < 64; i++) pay[i] = 8'h00;
    begin
      logic [15:0] f;
      f = fold_ref(2, cur_sp, cur_dp);
      pay[0] = ~f[15:8];
      pay[1] = ~f[7:0];
    end
    run_frame(2, 3, 1'b0, 16'h0, 16'h0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule